// File: doc/BRIEF.md
# IRQ Entry Return-Address Unit

This block sits at the retire end of a simple in-order processor pipeline. It watches the stream of retiring instructions and decides when a pending interrupt request may be taken. On entry it saves a link value, captures the instruction-set state and redirects fetch to the interrupt vector. The link value comes from the preferred return address, which is the instruction that would have run next if no interrupt had arrived, plus a fixed offset of 4.

The preferred return address is the branch target after a taken branch, and the sequential successor otherwise. The successor is 2 bytes on in the 16-bit encoding state and 4 bytes on in the 32-bit encoding state. A load-multiple retires one beat per register read. A policy input picks how an interrupt during such an instruction is handled. Under the abandon policy the instruction is dropped at a beat boundary and restarts from its own address after the handler. Under the complete policy it runs to its last beat first. The block also exports the value a PC-relative operand of the retiring instruction would see. That value is never used to form the link.

Top module: `irq_link_unit`

## Requirements
- R1: After reset, irq_taken, redirect_valid and irq_mask are 0, link_val is 0 and redirect_addr is 0.
- R2: When a sequential instruction retires with rt_half=0 (32-bit state) and the request is accepted, link_val becomes rt_addr+8 (0x1000 gives 0x1008).
- R3: When a sequential instruction retires with rt_half=1 (16-bit state) and the request is accepted, link_val becomes rt_addr+6 (0x1000 gives 0x1006).
- R4: When the retiring instruction has rt_br_taken=1, link_val becomes rt_br_target+4 in either state.
- R5: With lm_abandon=1, a load-multiple beat (rt_lm=1) that is not the last (rt_lm_last=0) is an accept point, and link_val becomes that instruction's own rt_addr+4.
- R6: With lm_abandon=0, non-last load-multiple beats are not accept points. The last beat is an accept point under either policy, and link_val becomes the sequential successor plus 4.
- R7: A request is never accepted in a cycle with rt_valid=0.
- R8: A request is never accepted while irq_disable=1.
- R9: An accepted request gives irq_taken=1 and redirect_valid=1 for exactly one cycle, starting the cycle after the accepting edge. In that cycle redirect_addr is 0x18 and saved_half equals the accepted retire's rt_half.
- R10: Entry sets irq_mask to 1. No further request is accepted until handler_ret clears it, after which acceptance resumes.
- R11: link_val keeps its value until the next accepted entry.
- R12: pcrel_val equals rt_addr+4 when rt_half=1 and rt_addr+8 when rt_half=0, combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rt_valid | input | 1 | A retire event (instruction or load-multiple beat) is present |
| rt_addr | input | AW | Address of the retiring instruction |
| rt_half | input | 1 | 1 = 16-bit encoding state, 0 = 32-bit encoding state |
| rt_br_taken | input | 1 | Retiring instruction is a taken branch |
| rt_br_target | input | AW | Target of the taken branch |
| rt_lm | input | 1 | Event is a load-multiple beat |
| rt_lm_last | input | 1 | The load-multiple beat is its final one |
| lm_abandon | input | 1 | Policy: 1 = abandon load-multiple, 0 = complete it |
| irq_req | input | 1 | Interrupt request level |
| irq_disable | input | 1 | Request is ignored while set |
| handler_ret | input | 1 | Return from handler; clears the entry mask |
| irq_taken | output | 1 | One-cycle entry pulse |
| link_val | output | AW | Saved link value |
| saved_half | output | 1 | Instruction-set state captured at entry |
| irq_mask | output | 1 | Entry mask, set on entry |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_addr | output | AW | Redirect address (vector while valid) |
| pcrel_val | output | AW | PC-relative operand value of the retiring instruction |

## Verification
On every cycle the assertions check these rules: the entry pulse lasts a single cycle, it agrees with the redirect strobe and the vector address, and it sets the mask. They also check that no entry follows a cycle that was masked or disabled, that the link stays stable between entries, and that sequential and abandoned-beat entries get the right link. Only the bench's scenarios can show the rest. These are the choice among branch target, successor and restart address across the two states and both policies, non-last beats being passed over under the complete policy, acceptance resuming after handler return, and the separation of the PC-relative value from the link.

// File: rtl/irq_link_pkg.sv
// Package: shared constants and types of the IRQ entry return-address unit.
// Assumes byte addressing; step and offset values follow the two encodings.
package irq_link_pkg;

    // address step of one sequential instruction in each encoding state
    localparam int unsigned STEP_W32 = 4;
    localparam int unsigned STEP_W16 = 2;

    // offset added to the preferred return address to form the IRQ link
    localparam int unsigned IRQ_LINK_OFS = 4;

    // PC-relative operand view: own address plus this amount
    localparam int unsigned PCREL_W32 = 8;
    localparam int unsigned PCREL_W16 = 4;

    // load-multiple interrupt policy
    typedef enum logic {
        LM_COMPLETE = 1'b0,
        LM_ABANDON  = 1'b1
    } lm_policy_e;

    // kind of accept point found in the current retire event
    typedef enum logic [1:0] {
        BND_NONE    = 2'd0,
        BND_RETIRE  = 2'd1,
        BND_RESTART = 2'd2
    } bnd_kind_e;

endpackage

// File: rtl/irq_boundary_detect.sv
// Module: irq_boundary_detect
// Classifies each retire event as an accept point or not, and computes the
// preferred return address for it. Assumes a load-multiple signals one event
// per beat with rt_lm=1, and that its final beat carries rt_lm_last=1.
module irq_boundary_detect
    import irq_link_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          rt_valid,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_half,
    input  logic          rt_br_taken,
    input  logic [AW-1:0] rt_br_target,
    input  logic          rt_lm,
    input  logic          rt_lm_last,
    input  lm_policy_e    policy,
    output logic          boundary,
    output logic [AW-1:0] pref_addr
);

    localparam logic [AW-1:0] STEP32 = AW'(STEP_W32);
    localparam logic [AW-1:0] STEP16 = AW'(STEP_W16);

    bnd_kind_e     kind;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] next_addr;

    // sequential successor according to the encoding state
    always_comb begin
        seq_addr = rt_addr + (rt_half ? STEP16 : STEP32);
    end

    // architecturally next instruction of a completed retire
    always_comb begin
        next_addr = rt_br_taken ? rt_br_target : seq_addr;
    end

    // decide which kind of accept point this event is
    always_comb begin
        kind = BND_NONE;
        if (rt_valid) begin
            if (!rt_lm || rt_lm_last) begin
                kind = BND_RETIRE;
            end else if (policy == LM_ABANDON) begin
                kind = BND_RESTART;
            end
        end
    end

    // select the preferred return address for the accept point
    always_comb begin
        unique case (kind)
            BND_RETIRE:  pref_addr = next_addr;
            BND_RESTART: pref_addr = rt_addr;
            default:     pref_addr = '0;
        endcase
        boundary = (kind != BND_NONE);
    end

endmodule

// File: rtl/irq_addr_calc.sv
// Module: irq_addr_calc
// Forms the IRQ link from the preferred return address, and separately the
// PC-relative operand view of the retiring instruction. The two paths share
// nothing; the PC-relative view never feeds the link.
module irq_addr_calc
    import irq_link_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pref_addr,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_half,
    output logic [AW-1:0] link_next,
    output logic [AW-1:0] pcrel_val
);

    localparam logic [AW-1:0] LINK_OFS = AW'(IRQ_LINK_OFS);
    localparam logic [AW-1:0] PC_OFS32 = AW'(PCREL_W32);
    localparam logic [AW-1:0] PC_OFS16 = AW'(PCREL_W16);

    // link value candidate: fixed offset in both encoding states
    always_comb begin
        link_next = pref_addr + LINK_OFS;
    end

    // PC value an operand of the retiring instruction observes
    always_comb begin
        pcrel_val = rt_addr + (rt_half ? PC_OFS16 : PC_OFS32);
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
// Module: irq_entry_ctrl
// Accepts the interrupt at an accept point, holds the link and saved state,
// owns the entry mask and drives the fetch redirect. Assumes irq_req is
// already synchronous to clk.
module irq_entry_ctrl #(
    parameter int unsigned     AW  = 32,
    parameter logic [AW-1:0]   VEC = 'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          irq_req,
    input  logic          irq_disable,
    input  logic          handler_ret,
    input  logic [AW-1:0] link_next,
    input  logic          rt_half,
    output logic          taken,
    output logic [AW-1:0] link_q,
    output logic          saved_half,
    output logic          mask_q,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr
);

    logic accept;

    // acceptance needs an accept point, an open mask and no disable
    always_comb begin
        accept = boundary && irq_req && !irq_disable && !mask_q;
    end

    // entry pulse, link and saved state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            link_q     <= '0;
            saved_half <= 1'b0;
        end else begin
            taken <= accept;
            if (accept) begin
                link_q     <= link_next;
                saved_half <= rt_half;
            end
        end
    end

    // entry mask: set on entry, cleared by return from handler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (accept) begin
            mask_q <= 1'b1;
        end else if (handler_ret) begin
            mask_q <= 1'b0;
        end
    end

    // fetch redirect follows the entry pulse
    always_comb begin
        redirect_valid = taken;
        redirect_addr  = taken ? VEC : '0;
    end

endmodule

// File: rtl/irq_link_unit.sv
// Module: irq_link_unit (top)
// Decides IRQ entry at the retire end of the pipeline and saves the link.
// Assumes one retire event per cycle at most, and a synchronous request.
module irq_link_unit
    import irq_link_pkg::*;
#(
    parameter int unsigned   AW  = 32,
    parameter logic [AW-1:0] VEC = 'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rt_valid,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_half,
    input  logic          rt_br_taken,
    input  logic [AW-1:0] rt_br_target,
    input  logic          rt_lm,
    input  logic          rt_lm_last,
    input  logic          lm_abandon,
    input  logic          irq_req,
    input  logic          irq_disable,
    input  logic          handler_ret,
    output logic          irq_taken,
    output logic [AW-1:0] link_val,
    output logic          saved_half,
    output logic          irq_mask,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr,
    output logic [AW-1:0] pcrel_val
);

    lm_policy_e    policy;
    logic          boundary;
    logic [AW-1:0] pref_addr;
    logic [AW-1:0] link_next;

    // map the policy pin onto its enumerated meaning
    always_comb begin
        policy = lm_abandon ? LM_ABANDON : LM_COMPLETE;
    end

    irq_boundary_detect #(.AW(AW)) u_bnd (
        .rt_valid     (rt_valid),
        .rt_addr      (rt_addr),
        .rt_half      (rt_half),
        .rt_br_taken  (rt_br_taken),
        .rt_br_target (rt_br_target),
        .rt_lm        (rt_lm),
        .rt_lm_last   (rt_lm_last),
        .policy       (policy),
        .boundary     (boundary),
        .pref_addr    (pref_addr)
    );

    irq_addr_calc #(.AW(AW)) u_calc (
        .pref_addr (pref_addr),
        .rt_addr   (rt_addr),
        .rt_half   (rt_half),
        .link_next (link_next),
        .pcrel_val (pcrel_val)
    );

    irq_entry_ctrl #(.AW(AW), .VEC(VEC)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .boundary       (boundary),
        .irq_req        (irq_req),
        .irq_disable    (irq_disable),
        .handler_ret    (handler_ret),
        .link_next      (link_next),
        .rt_half        (rt_half),
        .taken          (irq_taken),
        .link_q         (link_val),
        .saved_half     (saved_half),
        .mask_q         (irq_mask),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr)
    );

endmodule

// File: rtl/irq_link_unit_chk.sv
// Module: irq_link_unit_chk
// Cycle-level properties of the IRQ entry unit, bound to its top.
module irq_link_unit_chk #(
    parameter int unsigned   AW  = 32,
    parameter logic [AW-1:0] VEC = 'h18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rt_addr,
    input logic          rt_half,
    input logic          rt_br_taken,
    input logic          rt_lm,
    input logic          rt_lm_last,
    input logic          lm_abandon,
    input logic          irq_req,
    input logic          irq_disable,
    input logic          irq_taken,
    input logic [AW-1:0] link_val,
    input logic          irq_mask,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_addr
);

    AST_TAKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !irq_taken); // R9

    AST_REDIRECT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> (redirect_valid && redirect_addr == VEC)); // R9

    AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> irq_mask); // R10

    AST_NO_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> !$past(irq_mask)); // R10

    AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> ($past(irq_req) && !$past(irq_disable))); // R8

    AST_LINK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_taken |-> $stable(link_val)); // R11

    AST_SEQ_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && $past(!rt_lm && !rt_br_taken)) |->
        (link_val == $past(rt_addr) + ($past(rt_half) ? AW'(6) : AW'(8)))); // R2

    AST_ABANDON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && $past(rt_lm && !rt_lm_last)) |->
        ($past(lm_abandon) && link_val == $past(rt_addr) + AW'(4))); // R5

endmodule

bind irq_link_unit irq_link_unit_chk #(.AW(AW), .VEC(VEC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rt_addr        (rt_addr),
    .rt_half        (rt_half),
    .rt_br_taken    (rt_br_taken),
    .rt_lm          (rt_lm),
    .rt_lm_last     (rt_lm_last),
    .lm_abandon     (lm_abandon),
    .irq_req        (irq_req),
    .irq_disable    (irq_disable),
    .irq_taken      (irq_taken),
    .link_val       (link_val),
    .irq_mask       (irq_mask),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
);

// File: tb/irq_link_unit_tb.sv
`timescale 1ns/1ps
module irq_link_unit_tb;

    localparam int unsigned AW = 32;

    typedef struct packed {
        logic        half;
        logic        br;
        logic        lm;
        logic        last;
        logic        abandon;
        logic        take;
        logic [31:0] addr;
        logic [31:0] tgt;
        logic [31:0] link;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h0,    32'h1008},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h0,    32'h1006},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1100, 32'h2000, 32'h2004},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1102, 32'h3002, 32'h3006},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, 32'h0,    32'h4004},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h5000, 32'h0,    32'h5004},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h6000, 32'h0,    32'h5004},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h6000, 32'h0,    32'h6008},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h7000, 32'h0,    32'h7006}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rt_valid, rt_half, rt_br_taken, rt_lm, rt_lm_last;
    logic [AW-1:0] rt_addr, rt_br_target;
    logic          lm_abandon, irq_req, irq_disable, handler_ret;
    logic          irq_taken, saved_half, irq_mask, redirect_valid;
    logic [AW-1:0] link_val, redirect_addr, pcrel_val;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_link_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_addr(rt_addr),
        .rt_half(rt_half), .rt_br_taken(rt_br_taken), .rt_br_target(rt_br_target),
        .rt_lm(rt_lm), .rt_lm_last(rt_lm_last), .lm_abandon(lm_abandon),
        .irq_req(irq_req), .irq_disable(irq_disable), .handler_ret(handler_ret),
        .irq_taken(irq_taken), .link_val(link_val), .saved_half(saved_half),
        .irq_mask(irq_mask), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .pcrel_val(pcrel_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.lm && !v.last) return v.abandon ? "R5" : "R6";
        if (v.lm)            return "R6";
        if (v.br)            return "R4";
        return v.half ? "R3" : "R2";
    endfunction

    task automatic idle_inputs();
        rt_valid = 0; rt_half = 0; rt_br_taken = 0; rt_lm = 0; rt_lm_last = 0;
        rt_addr = '0; rt_br_target = '0; irq_req = 0; handler_ret = 0;
    endtask

    task automatic drive_seq(input logic [31:0] a, input logic h);
        rt_valid = 1; rt_addr = a; rt_half = h; rt_br_taken = 0;
        rt_lm = 0; rt_lm_last = 0; irq_req = 1;
    endtask

    task automatic ret_pulse();
        @(negedge clk); handler_ret = 1;
        @(negedge clk); handler_ret = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        lm_abandon = 0; irq_disable = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 taken", 32'(irq_taken), 0);
        chk("R1 redirect_valid", 32'(redirect_valid), 0);
        chk("R1 mask", 32'(irq_mask), 0);
        chk("R1 link", link_val, 0);
        chk("R1 redirect_addr", redirect_addr, 0);
        rst_n = 1;

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rt_valid = 1; rt_addr = TBL[i].addr; rt_half = TBL[i].half;
            rt_br_taken = TBL[i].br; rt_br_target = TBL[i].tgt;
            rt_lm = TBL[i].lm; rt_lm_last = TBL[i].last;
            lm_abandon = TBL[i].abandon; irq_req = 1;
            @(negedge clk);
            idle_inputs();
            chk(tag_of(TBL[i]), 32'(irq_taken), 32'(TBL[i].take));
            chk(tag_of(TBL[i]), link_val, TBL[i].link);
            if (TBL[i].take) begin
                chk("R9 saved_half", 32'(saved_half), 32'(TBL[i].half));
                chk("R9 redirect_addr", redirect_addr, 32'h18);
                chk("R9 redirect_valid", 32'(redirect_valid), 1);
                chk("R10 mask set", 32'(irq_mask), 1);
            end
            @(negedge clk);
            chk("R9 pulse end", 32'(irq_taken), 0);
            ret_pulse();
        end
        lm_abandon = 0;

        // R12 PC-relative view
        @(negedge clk);
        rt_addr = 32'h1000; rt_half = 1; #1;
        chk("R12 16-bit", pcrel_val, 32'h1004);
        rt_half = 0; #1;
        chk("R12 32-bit", pcrel_val, 32'h1008);
        idle_inputs();

        // R7 no retire event: request pending but nothing accepted
        @(negedge clk); irq_req = 1;
        repeat (3) @(negedge clk);
        chk("R7 no retire", 32'(irq_taken), 0);
        chk("R7 mask", 32'(irq_mask), 0);
        chk("R11 link held", link_val, 32'h7006);
        idle_inputs();

        // R10 mask blocks re-entry until handler_ret
        @(negedge clk); drive_seq(32'h8000, 0);
        @(negedge clk);
        chk("R2 entry", link_val, 32'h8008);
        chk("R9 taken", 32'(irq_taken), 1);
        rt_addr = 32'h8004;
        @(negedge clk);
        chk("R9 single cycle", 32'(irq_taken), 0);
        chk("R10 mask held", 32'(irq_mask), 1);
        @(negedge clk);
        chk("R10 masked retire", 32'(irq_taken), 0);
        chk("R11 link held", link_val, 32'h8008);
        rt_valid = 0; handler_ret = 1;
        @(negedge clk);
        handler_ret = 0;
        chk("R10 mask cleared", 32'(irq_mask), 0);
        drive_seq(32'h9000, 0);
        @(negedge clk);
        idle_inputs();
        chk("R10 re-entry", 32'(irq_taken), 1);
        chk("R10 re-entry link", link_val, 32'h9008);
        ret_pulse();

        // R8 disable blocks acceptance
        @(negedge clk); irq_disable = 1; drive_seq(32'hA000, 1);
        @(negedge clk);
        chk("R8 disabled", 32'(irq_taken), 0);
        chk("R8 link kept", link_val, 32'h9008);
        irq_disable = 0;
        @(negedge clk);
        idle_inputs();
        chk("R8 enabled", 32'(irq_taken), 1);
        chk("R3 link", link_val, 32'hA006);
        chk("R9 saved_half", 32'(saved_half), 1);
        ret_pulse();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule